// File: doc/BRIEF.md
# Debug Test Access Port

This block is the serial front end of a debug transport module. It watches three
board-level test pins (test clock, mode select and serial data in), carries them
into the system clock domain, and steps the standard sixteen-state test access
port controller once for each rising edge of the test clock. Depending on the
controller state, it shifts a 5-bit instruction register or a data register. It
drives the low bit of whichever register is being shifted onto the serial data
output.

The data register is loaded in Capture-DR. Its value and length depend on the
current instruction. The identification instruction loads a fixed 32-bit
identity word. The transport-control instruction loads a 32-bit status word
taken from a parallel input. Any other instruction leaves the data register as
it was, so a debugger can shift a pattern in and read the same pattern back
later. Update-DR does nothing, and shifted data is not written anywhere.

Top module: `dbg_tap_port`

## Requirements
- R1: The test pins pass through a two-stage synchronizer and are then compared with their values one system clock earlier. State, registers and `tdo_o` change only in response to a detected rising test-clock edge. While the test clock is low, or when it falls, `tdo_o` holds its value.
- R2: On each rising edge the controller moves to the next state given by the standard transition table. The table is indexed by the current state and the mode-select value held just before the edge. Five consecutive edges with mode select high reach Test-Logic-Reset from any state.
- R3: On a rising edge taken while in Shift-DR, the data register shifts right by one place. The data-in value held before the edge enters at bit (length − 1), which is bit 31 for the 32-bit length. This shift happens before the state advances on the same edge.
- R4: On a rising edge taken while in Shift-IR, the 5-bit instruction register shifts right by one place and the data-in value enters at bit 4.
- R5: On every entry into Test-Logic-Reset, the instruction register is loaded with the identification instruction, 5'h01.
- R6: On entry into Capture-DR with instruction 5'h01, the data register is loaded with 32'hDEADBEEF and its length is set to 32.
- R7: On entry into Capture-DR with instruction 5'h10, the data register is loaded with the value on `ctrl_word_i` and its length is set to 32.
- R8: On entry into, or while staying in, Shift-DR, `tdo_o` takes bit 0 of the data register as it stands after that edge. Shift-IR does the same with the instruction register. In all other states `tdo_o` is held.
- R9: On entry into Capture-DR with any instruction other than 5'h01 or 5'h10, the data register and its length are left unchanged.
- R10: Entering Capture-IR, Update-IR or Update-DR changes neither register.
- R11: An active-high asynchronous reset sets the following: controller in Test-Logic-Reset, instruction register 5'h01, data register zero with length 32, and `tdo_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| tck_i | input | 1 | Test clock pin, asynchronous |
| tms_i | input | 1 | Test mode select pin, asynchronous |
| tdi_i | input | 1 | Test serial data in, asynchronous |
| ctrl_word_i | input | 32 | Status word captured under instruction 5'h10 |
| tdo_o | output | 1 | Test serial data out |

## Verification
The reset contents of the data register are the hardest thing to see from the pins. Reset selects the identification instruction, and every Test-Logic-Reset entry selects it again, so any capture after either event normally overwrites the register with the identity word. To avoid this, the stimulus leaves reset and walks straight to the instruction scan. It loads an instruction that selects no capture source and then runs a full data scan, which shifts the reset zeros out while a known pattern goes in. A second scan under the same instruction then reads the pattern back. That confirms the 32-bit length and shows that the unselected capture and Update-DR left the register alone. A long pseudo-random pin sweep, compared edge by edge against an arithmetic model in the bench, covers the pause and exit paths of the controller.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  // Controller transition table: current state and mode select -> next state
  function automatic tap_state_e tap_next(input tap_state_e s, input logic sel);
    tap_state_e n;
    case (s)
      TS_RESET:  n = sel ? TS_RESET  : TS_IDLE;
      TS_IDLE:   n = sel ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: n = sel ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: n = sel ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: n = sel ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: n = sel ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: n = sel ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: n = sel ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: n = sel ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: n = sel ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: n = sel ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: n = sel ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: n = sel ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: n = sel ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: n = sel ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: n = sel ? TS_SEL_DR : TS_IDLE;
      default:   n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dbg_tap_sync.sv
module dbg_tap_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       sel_i,
  output tap_state_e state_o,
  output tap_state_e next_o
);
  assign next_o = step_i ? tap_next(state_o, sel_i) : state_o;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_o <= TS_RESET;
    else     state_o <= next_o;
  end

  // R1: controller waits for a test clock rising edge
  assert_state_waits_R1: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(state_o));

  // R2: mode select high holds reset; low holds shift
  assert_reset_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && sel_i && state_o == TS_RESET) |=> state_o == TS_RESET);
  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !sel_i && state_o == TS_SHF_DR) |=> state_o == TS_SHF_DR);
endmodule

// File: rtl/dbg_tap_regs.sv
module dbg_tap_regs
  import dbg_tap_pkg::*;
#(
  parameter int              IR_W      = 5,
  parameter int              DR_W      = 32,
  parameter logic [IR_W-1:0] IR_IDCODE = 5'h01,
  parameter logic [IR_W-1:0] IR_CTRL   = 5'h10,
  parameter logic [DR_W-1:0] ID_WORD   = 32'hDEADBEEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  input  tap_state_e      next_i,
  input  logic [DR_W-1:0] ctrl_word_i,
  output logic            tdo_o
);
  localparam int LEN_W = $clog2(DR_W + 1);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DR_W);

  logic [IR_W-1:0]  ir_q, ir_sh, ir_d;
  logic [DR_W-1:0]  dr_q, dr_sh, dr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             tdo_d;

  // Right shift; the new bit lands at position (len - 1)
  function automatic logic [DR_W-1:0] dr_shift(input logic [DR_W-1:0] v,
                                               input logic [LEN_W-1:0] n,
                                               input logic b);
    logic [DR_W-1:0] pos;
    pos = {{(DR_W-1){1'b0}}, 1'b1} << (n - LEN_W'(1));
    return (v >> 1) | (b ? pos : '0);
  endfunction

  // Named events for the assertions
  logic shift_dr_ev, shift_ir_ev, cap_dr_ev, enter_reset_ev;
  assign shift_dr_ev    = step_i && state_i == TS_SHF_DR;
  assign shift_ir_ev    = step_i && state_i == TS_SHF_IR;
  assign cap_dr_ev      = step_i && next_i == TS_CAP_DR;
  assign enter_reset_ev = step_i && next_i == TS_RESET;

  always_comb begin
    ir_sh = shift_ir_ev ? {tdi_i, ir_q[IR_W-1:1]} : ir_q;
    dr_sh = shift_dr_ev ? dr_shift(dr_q, len_q, tdi_i) : dr_q;
    ir_d  = ir_sh;
    dr_d  = dr_sh;
    len_d = len_q;
    tdo_d = tdo_q_r;
    if (step_i) begin
      case (next_i)
        TS_RESET:  ir_d = IR_IDCODE;
        TS_CAP_DR: begin
          if (ir_sh == IR_IDCODE) begin
            dr_d  = ID_WORD;
            len_d = FULL_LEN;
          end else if (ir_sh == IR_CTRL) begin
            dr_d  = ctrl_word_i;
            len_d = FULL_LEN;
          end
        end
        TS_SHF_DR: tdo_d = dr_sh[0];
        TS_SHF_IR: tdo_d = ir_sh[0];
        default:   ;
      endcase
    end
  end

  logic tdo_q_r;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ir_q    <= IR_IDCODE;
      dr_q    <= '0;
      len_q   <= FULL_LEN;
      tdo_q_r <= 1'b0;
    end else begin
      ir_q    <= ir_d;
      dr_q    <= dr_d;
      len_q   <= len_d;
      tdo_q_r <= tdo_d;
    end
  end
  assign tdo_o = tdo_q_r;

  assert_tdo_waits_R1: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(tdo_o));
  assert_ir_shift_R4: assert property (@(posedge clk) disable iff (rst)
    shift_ir_ev |=> ir_q[IR_W-1] == $past(tdi_i));
  assert_idcode_load_R5: assert property (@(posedge clk) disable iff (rst)
    enter_reset_ev |=> ir_q == IR_IDCODE);
  assert_capture_id_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_dr_ev && ir_q == IR_IDCODE) |=> dr_q == ID_WORD);
  assert_capture_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_dr_ev && ir_q == IR_CTRL) |=> dr_q == $past(ctrl_word_i));
  assert_tdo_dr_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && next_i == TS_SHF_DR) |=> tdo_o == dr_q[0]);
  assert_other_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (cap_dr_ev && ir_q != IR_IDCODE && ir_q != IR_CTRL) |=> $stable(dr_q) && $stable(len_q));
  assert_quiet_states_R10: assert property (@(posedge clk) disable iff (rst)
    (step_i && (next_i == TS_CAP_IR || next_i == TS_UPD_IR || next_i == TS_UPD_DR))
      |=> $stable(dr_q) && $stable(ir_q));
endmodule

// File: rtl/dbg_tap_port.sv
module dbg_tap_port
  import dbg_tap_pkg::*;
#(
  parameter int              IR_W        = 5,
  parameter int              DR_W        = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [IR_W-1:0] IR_IDCODE   = 5'h01,
  parameter logic [IR_W-1:0] IR_CTRL     = 5'h10,
  parameter logic [DR_W-1:0] ID_WORD     = 32'hDEADBEEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tck_i,
  input  logic            tms_i,
  input  logic            tdi_i,
  input  logic [DR_W-1:0] ctrl_word_i,
  output logic            tdo_o
);
  logic [2:0] pins_s, pins_q;
  tap_state_e state, state_nx;
  logic       tck_rise;

  dbg_tap_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({tck_i, tms_i, tdi_i}), .q_o(pins_s)
  );

  // Previous synchronized pin values: mode select and data held before the edge
  always_ff @(posedge clk or posedge rst) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pins_s;
  end

  assign tck_rise = pins_s[2] & ~pins_q[2];

  dbg_tap_fsm u_fsm (
    .clk(clk), .rst(rst), .step_i(tck_rise), .sel_i(pins_q[1]),
    .state_o(state), .next_o(state_nx)
  );

  dbg_tap_regs #(
    .IR_W(IR_W), .DR_W(DR_W), .IR_IDCODE(IR_IDCODE),
    .IR_CTRL(IR_CTRL), .ID_WORD(ID_WORD)
  ) u_regs (
    .clk(clk), .rst(rst), .step_i(tck_rise), .tdi_i(pins_q[0]),
    .state_i(state), .next_i(state_nx), .ctrl_word_i(ctrl_word_i),
    .tdo_o(tdo_o)
  );

  // R1: one detected edge per test clock rise
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
    tck_rise |=> !tck_rise);
endmodule

// File: tb/dbg_tap_port_tb.sv
`timescale 1ns/1ps
module dbg_tap_port_tb;
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5,
                 S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_HIR = 11,
                 S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

  logic clk = 0, rst = 1, tck_r = 0, tms_r = 0, tdi_r = 0;
  logic [31:0] ctrl_r = 32'h0;
  logic tdo;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  int m_st = S_TLR;
  logic [4:0] m_ir = 5'h01;
  logic [31:0] m_dr = 32'h0;
  logic m_tdo = 1'b0;

  always #2.5 clk = ~clk;

  dbg_tap_port u_dut (
    .clk(clk), .rst(rst), .tck_i(tck_r), .tms_i(tms_r), .tdi_i(tdi_r),
    .ctrl_word_i(ctrl_r), .tdo_o(tdo)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  function automatic int succ(input int s, input logic m);
    if (s == S_TLR) return m ? S_TLR : S_RTI;
    if (s == S_RTI || s == S_UDR || s == S_UIR) return m ? S_SDR : S_RTI;
    if (s == S_SDR) return m ? S_SIR : S_CDR;
    if (s == S_SIR) return m ? S_TLR : S_CIR;
    if (s == S_CDR || s == S_HDR) return m ? S_E1D : S_HDR;
    if (s == S_CIR || s == S_HIR) return m ? S_E1I : S_HIR;
    if (s == S_E1D) return m ? S_UDR : S_PDR;
    if (s == S_E1I) return m ? S_UIR : S_PIR;
    if (s == S_PDR) return m ? S_E2D : S_PDR;
    if (s == S_PIR) return m ? S_E2I : S_PIR;
    if (s == S_E2D) return m ? S_UDR : S_HDR;
    return m ? S_UIR : S_HIR;
  endfunction

  task automatic model_edge(input logic m, input logic d);
    if (m_st == S_HDR) m_dr = {d, m_dr[31:1]};
    if (m_st == S_HIR) m_ir = {d, m_ir[4:1]};
    m_st = succ(m_st, m);
    if (m_st == S_TLR) m_ir = 5'h01;
    if (m_st == S_CDR && m_ir == 5'h01) m_dr = 32'hDEADBEEF;
    if (m_st == S_CDR && m_ir == 5'h10) m_dr = ctrl_r;
    if (m_st == S_HDR) m_tdo = m_dr[0];
    if (m_st == S_HIR) m_tdo = m_ir[0];
  endtask

  task automatic pulse(input logic m, input logic d);
    @(negedge clk);
    tms_r = m; tdi_r = d;
    repeat (4) @(negedge clk);
    chk("R1 tdo held while TCK low", {31'b0, tdo}, {31'b0, m_tdo});
    tck_r = 1;
    model_edge(m, d);
    repeat (6) @(negedge clk);
    chk("R2/R8 tdo after rising edge", {31'b0, tdo}, {31'b0, m_tdo});
    tck_r = 0;
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b0);
  endtask

  // From Run-Test/Idle: scan new IR, return previous IR contents; end in idle
  task automatic scan_ir(input logic [4:0] nv, output logic [4:0] old);
    pulse(1, 0); pulse(1, 0); pulse(0, 0); pulse(0, 0);
    old[0] = tdo;
    for (int i = 0; i < 5; i++) begin
      pulse(i == 4, nv[i]);
      if (i < 4) old[i+1] = tdo;
    end
    pulse(1, 0); pulse(0, 0);
  endtask

  // From Run-Test/Idle: scan 32 bits in, return the 32 bits seen; end in idle
  task automatic scan_dr(input logic [31:0] nv, output logic [31:0] got);
    pulse(1, 0); pulse(0, 0); pulse(0, 0);
    got[0] = tdo;
    for (int i = 0; i < 32; i++) begin
      pulse(i == 31, nv[i]);
      if (i < 31) got[i+1] = tdo;
    end
    pulse(1, 0); pulse(0, 0);
  endtask

  initial begin
    logic [4:0] oir;
    logic [31:0] odr;
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    chk("R11 tdo low after reset", {31'b0, tdo}, 32'h0);

    // leave reset without passing Test-Logic-Reset again
    pulse(0, 0);
    scan_ir(5'h03, oir);
    chk("R11 reset IR is 5'h01", {27'b0, oir}, 32'h01);
    scan_dr(32'hA5A5F00F, odr);
    chk("R11 reset DR zero, R9 capture kept it", odr, 32'h0);
    scan_dr(32'h0, odr);
    chk("R3 R9 R10 pattern survives, length 32", odr, 32'hA5A5F00F);
    scan_ir(5'h10, oir);
    chk("R4 R10 IR read back", {27'b0, oir}, 32'h03);

    ctrl_r = 32'h1234_5678;
    scan_dr(32'hFFFF_FFFF, odr);
    chk("R7 control word captured", odr, 32'h1234_5678);
    ctrl_r = 32'h8000_0001;
    scan_dr(32'h0, odr);
    chk("R7 second control word", odr, 32'h8000_0001);

    to_idle();
    scan_ir(5'h1F, oir);
    chk("R5 IR reloaded by Test-Logic-Reset", {27'b0, oir}, 32'h01);
    to_idle();
    scan_dr(32'h0, odr);
    chk("R6 identity word", odr, 32'hDEADBEEF);

    // pause/exit2 path: shift 8, pause, resume
    pulse(1, 0); pulse(0, 0); pulse(0, 0);
    for (int i = 0; i < 8; i++) pulse(0, 1);
    pulse(1, 1); pulse(0, 0); pulse(0, 0); pulse(1, 0); pulse(0, 0);
    chk("R8 tdo on Shift-DR re-entry", {31'b0, tdo}, {31'b0, m_tdo});
    to_idle();

    // pseudo-random pin sweep against the bench model
    lf = 16'hACE1;
    for (int p = 0; p < 3000; p++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (p % 64 == 0) ctrl_r = {lf, ~lf};
      pulse(lf[3:1] == 3'b000 || lf[5:3] == 3'b111, lf[8]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule